// File: doc/BRIEF.md
# Decode-Born Pipeline Control Chain

This block moves decoded control information down a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). The decoder produces a complete control bundle for the instruction that sits in decode. The bundle holds an opcode, a destination register number, a register-write enable, the execute-stage fields, the memory-stage fields and the writeback-stage fields. The chain latches the bundle at the decode/execute boundary and then hands the remaining parts from stage to stage. Each stage therefore sees the controls of the instruction it holds, however the pipeline has been stalled or cleared.

Two requests steer the chain. A stall request says the instruction in decode cannot proceed: fetch and decode are held, and an empty slot enters execute while the older instructions drain. A flush request empties every stage register, and it wins when both requests arrive in the same cycle. Each stage has a valid bit, and no write or branch enable reaches the ports from a stage whose valid bit is clear.

Top module: `ds_ctl_chain`

## Requirements
- R1: In the first cycle after a synchronous reset, all four stage valid outputs (decode, execute, memory, writeback) read 0.
- R2: When decode holds a valid instruction and neither stall nor flush is asserted, its execute fields (extend select, ALU source select, 4-bit ALU operation, destination select) appear on the execute outputs one clock later, with the execute valid output at 1.
- R3: The memory-stage fields (memory write, branch) of that instruction appear on the memory outputs two clocks after decode, with the memory valid output at 1.
- R4: The writeback-stage fields (memory-to-register select, register write) of that instruction appear on the writeback outputs three clocks after decode, with the writeback valid output at 1.
- R5: While stall is asserted without flush, the hold output is 1, the decode valid bit keeps its value, the execute valid output is 0 after the clock, and the instructions already in execute and memory still move one stage on.
- R6: A stage whose valid bit is 0 drives its memory write, branch and register write outputs at 0, whatever its stored fields hold.
- R7: A flush clears the decode, execute, memory and writeback valid outputs at the next clock.
- R8: When flush and stall are asserted together, flush wins: the hold output is 0 and every valid output is 0 after the clock.
- R9: When not held, the decode valid bit loads the fetch valid input at each clock.
- R10: The opcode (6 bits) and destination register number (5 bits) of an instruction travel with it and are shown unchanged at the execute, memory and writeback outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid_i | input | 1 | Fetch stage holds a real instruction |
| stall_i | input | 1 | Decode instruction cannot proceed |
| flush_i | input | 1 | Empty all stage registers |
| dec_opcode_i | input | 6 | Opcode of the decode instruction |
| dec_rd_i | input | 5 | Destination register number |
| dec_reg_wr_i | input | 1 | Register write enable |
| dec_ext_op_i | input | 1 | Immediate extend select |
| dec_alu_src_i | input | 1 | ALU second operand select |
| dec_alu_op_i | input | 4 | ALU operation |
| dec_dst_sel_i | input | 1 | Destination field select |
| dec_mem_wr_i | input | 1 | Memory write enable |
| dec_branch_i | input | 1 | Branch instruction |
| dec_mem_to_reg_i | input | 1 | Writeback data from memory |
| hold_o | output | 1 | Freeze fetch and decode |
| id_valid_o | output | 1 | Decode stage valid |
| ex_valid_o | output | 1 | Execute stage valid |
| ex_opcode_o | output | 6 | Execute stage opcode |
| ex_rd_o | output | 5 | Execute stage destination |
| ex_ext_op_o | output | 1 | Extend select |
| ex_alu_src_o | output | 1 | ALU source select |
| ex_alu_op_o | output | 4 | ALU operation |
| ex_dst_sel_o | output | 1 | Destination select |
| mem_valid_o | output | 1 | Memory stage valid |
| mem_opcode_o | output | 6 | Memory stage opcode |
| mem_rd_o | output | 5 | Memory stage destination |
| mem_wr_o | output | 1 | Qualified memory write |
| mem_branch_o | output | 1 | Qualified branch |
| wb_valid_o | output | 1 | Writeback stage valid |
| wb_opcode_o | output | 6 | Writeback stage opcode |
| wb_rd_o | output | 5 | Writeback stage destination |
| wb_reg_wr_o | output | 1 | Qualified register write |
| wb_mem_to_reg_o | output | 1 | Memory-to-register select |

## Verification
A wrong valid bit shows first as an empty or spurious stage at the ports, and it shows as early as the next clock. A dropped bubble duplicates the stalled instruction into execute, and a missed flush lets a write enable reach the writeback outputs up to three clocks later. A slip in the latching order shows as a field arriving one stage early or late, or as fields from two different instructions appearing together. The directed scenarios therefore sample every stage in the exact cycle an instruction should reach it, and also in the cycle before.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    parameter int OP_W  = 6;
    parameter int REG_W = 5;
    parameter int ALU_W = 4;

    typedef struct packed {
        logic [OP_W-1:0]  opcode;
        logic [REG_W-1:0] rd;
        logic             reg_wr;
    } ins_tag_t;

    typedef struct packed {
        logic             ext_op;
        logic             alu_src;
        logic [ALU_W-1:0] alu_op;
        logic             dst_sel;
    } ex_ctl_t;

    typedef struct packed {
        logic mem_wr;
        logic branch;
    } mem_ctl_t;

    typedef struct packed {
        logic mem_to_reg;
    } wb_ctl_t;

    typedef struct packed {
        ins_tag_t tag;
        ex_ctl_t  ex;
        mem_ctl_t mem;
        wb_ctl_t  wb;
    } idex_t;

    typedef struct packed {
        ins_tag_t tag;
        mem_ctl_t mem;
        wb_ctl_t  wb;
    } exmem_t;

    typedef struct packed {
        ins_tag_t tag;
        wb_ctl_t  wb;
    } memwb_t;

    localparam int IDEX_W  = $bits(idex_t);
    localparam int EXMEM_W = $bits(exmem_t);
    localparam int MEMWB_W = $bits(memwb_t);

    // Drop the execute fields once they have been consumed.
    function automatic exmem_t strip_ex(input idex_t s);
        exmem_t r;
        r.tag = s.tag;
        r.mem = s.mem;
        r.wb  = s.wb;
        return r;
    endfunction

    // Drop the memory fields once they have been consumed.
    function automatic memwb_t strip_mem(input exmem_t s);
        memwb_t r;
        r.tag = s.tag;
        r.wb  = s.wb;
        return r;
    endfunction

    function automatic logic qualify(input logic v, input logic en);
        return v & en;
    endfunction

endpackage

// File: rtl/dsc_hold_ctl.sv
module dsc_hold_ctl (
    input  logic clk,
    input  logic rst,
    input  logic fetch_valid,
    input  logic stall,
    input  logic flush,
    output logic hold,
    output logic id_valid,
    output logic issue_valid,
    output logic kill
);
    logic id_v_q;

    // Flush outranks stall: a flushed pipe must not stay frozen.
    assign kill        = flush;
    assign hold        = stall & ~flush;
    assign issue_valid = id_v_q & ~stall;
    assign id_valid    = id_v_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            id_v_q <= 1'b0;
        end else if (kill) begin
            id_v_q <= 1'b0;
        end else if (!hold) begin
            id_v_q <= fetch_valid;
        end
    end
endmodule

// File: rtl/dsc_slot.sv
module dsc_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         kill,
    input  logic         valid_d,
    input  logic [W-1:0] data_d,
    output logic         valid_q,
    output logic [W-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            if (kill) begin
                valid_q <= 1'b0;
            end else if (load) begin
                valid_q <= valid_d;
            end
            if (load) begin
                data_q <= data_d;
            end
        end
    end
endmodule

// File: rtl/dsc_out_gate.sv
module dsc_out_gate
    import dsc_pkg::*;
(
    input  logic   mem_valid,
    input  exmem_t mem_s,
    input  logic   wb_valid,
    input  memwb_t wb_s,
    output logic   mem_wr_en,
    output logic   branch_en,
    output logic   reg_wr_en
);
    always_comb begin
        mem_wr_en = qualify(mem_valid, mem_s.mem.mem_wr);
        branch_en = qualify(mem_valid, mem_s.mem.branch);
        reg_wr_en = qualify(wb_valid, wb_s.tag.reg_wr);
    end
endmodule

// File: rtl/ds_ctl_chain.sv
module ds_ctl_chain
    import dsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_valid_i,
    input  logic             stall_i,
    input  logic             flush_i,
    input  logic [OP_W-1:0]  dec_opcode_i,
    input  logic [REG_W-1:0] dec_rd_i,
    input  logic             dec_reg_wr_i,
    input  logic             dec_ext_op_i,
    input  logic             dec_alu_src_i,
    input  logic [ALU_W-1:0] dec_alu_op_i,
    input  logic             dec_dst_sel_i,
    input  logic             dec_mem_wr_i,
    input  logic             dec_branch_i,
    input  logic             dec_mem_to_reg_i,
    output logic             hold_o,
    output logic             id_valid_o,
    output logic             ex_valid_o,
    output logic [OP_W-1:0]  ex_opcode_o,
    output logic [REG_W-1:0] ex_rd_o,
    output logic             ex_ext_op_o,
    output logic             ex_alu_src_o,
    output logic [ALU_W-1:0] ex_alu_op_o,
    output logic             ex_dst_sel_o,
    output logic             mem_valid_o,
    output logic [OP_W-1:0]  mem_opcode_o,
    output logic [REG_W-1:0] mem_rd_o,
    output logic             mem_wr_o,
    output logic             mem_branch_o,
    output logic             wb_valid_o,
    output logic [OP_W-1:0]  wb_opcode_o,
    output logic [REG_W-1:0] wb_rd_o,
    output logic             wb_reg_wr_o,
    output logic             wb_mem_to_reg_o
);
    logic issue_v, kill;
    logic ex_v, mem_v, wb_v;
    logic [IDEX_W-1:0]  idex_raw;
    logic [EXMEM_W-1:0] exmem_raw;
    logic [MEMWB_W-1:0] memwb_raw;
    idex_t  dec_s, ex_s;
    exmem_t mem_s;
    memwb_t wb_s;

    dsc_hold_ctl u_hold (
        .clk         (clk),
        .rst         (rst),
        .fetch_valid (fetch_valid_i),
        .stall       (stall_i),
        .flush       (flush_i),
        .hold        (hold_o),
        .id_valid    (id_valid_o),
        .issue_valid (issue_v),
        .kill        (kill)
    );

    always_comb begin
        dec_s.tag.opcode     = dec_opcode_i;
        dec_s.tag.rd         = dec_rd_i;
        dec_s.tag.reg_wr     = dec_reg_wr_i;
        dec_s.ex.ext_op      = dec_ext_op_i;
        dec_s.ex.alu_src     = dec_alu_src_i;
        dec_s.ex.alu_op      = dec_alu_op_i;
        dec_s.ex.dst_sel     = dec_dst_sel_i;
        dec_s.mem.mem_wr     = dec_mem_wr_i;
        dec_s.mem.branch     = dec_branch_i;
        dec_s.wb.mem_to_reg  = dec_mem_to_reg_i;
    end

    // Downstream slots always advance; a stall only empties the issue slot.
    dsc_slot #(.W(IDEX_W)) u_idex (
        .clk(clk), .rst(rst), .load(1'b1), .kill(kill),
        .valid_d(issue_v), .data_d(dec_s),
        .valid_q(ex_v), .data_q(idex_raw)
    );
    assign ex_s = idex_t'(idex_raw);

    dsc_slot #(.W(EXMEM_W)) u_exmem (
        .clk(clk), .rst(rst), .load(1'b1), .kill(kill),
        .valid_d(ex_v), .data_d(strip_ex(ex_s)),
        .valid_q(mem_v), .data_q(exmem_raw)
    );
    assign mem_s = exmem_t'(exmem_raw);

    dsc_slot #(.W(MEMWB_W)) u_memwb (
        .clk(clk), .rst(rst), .load(1'b1), .kill(kill),
        .valid_d(mem_v), .data_d(strip_mem(mem_s)),
        .valid_q(wb_v), .data_q(memwb_raw)
    );
    assign wb_s = memwb_t'(memwb_raw);

    dsc_out_gate u_gate (
        .mem_valid (mem_v),
        .mem_s     (mem_s),
        .wb_valid  (wb_v),
        .wb_s      (wb_s),
        .mem_wr_en (mem_wr_o),
        .branch_en (mem_branch_o),
        .reg_wr_en (wb_reg_wr_o)
    );

    assign ex_valid_o      = ex_v;
    assign ex_opcode_o     = ex_s.tag.opcode;
    assign ex_rd_o         = ex_s.tag.rd;
    assign ex_ext_op_o     = ex_s.ex.ext_op;
    assign ex_alu_src_o    = ex_s.ex.alu_src;
    assign ex_alu_op_o     = ex_s.ex.alu_op;
    assign ex_dst_sel_o    = ex_s.ex.dst_sel;
    assign mem_valid_o     = mem_v;
    assign mem_opcode_o    = mem_s.tag.opcode;
    assign mem_rd_o        = mem_s.tag.rd;
    assign wb_valid_o      = wb_v;
    assign wb_opcode_o     = wb_s.tag.opcode;
    assign wb_rd_o         = wb_s.tag.rd;
    assign wb_mem_to_reg_o = wb_s.wb.mem_to_reg;
endmodule

// File: rtl/dsc_chain_chk.sv
module dsc_chain_chk
    import dsc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             stall_i,
    input logic             flush_i,
    input logic             hold_o,
    input logic             id_valid_o,
    input logic             ex_valid_o,
    input logic [REG_W-1:0] ex_rd_o,
    input logic             mem_valid_o,
    input logic [REG_W-1:0] mem_rd_o,
    input logic             mem_wr_o,
    input logic             mem_branch_o,
    input logic             wb_valid_o,
    input logic [REG_W-1:0] wb_rd_o,
    input logic             wb_reg_wr_o
);
    logic was_rst;
    always_ff @(posedge clk) was_rst <= rst;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        was_rst |-> !id_valid_o && !ex_valid_o && !mem_valid_o && !wb_valid_o);

    assert_ex_to_mem_R3: assert property (@(posedge clk) disable iff (rst)
        ex_valid_o && !flush_i |=> mem_valid_o && mem_rd_o == $past(ex_rd_o));

    assert_mem_to_wb_R4: assert property (@(posedge clk) disable iff (rst)
        mem_valid_o && !flush_i |=> wb_valid_o && wb_rd_o == $past(mem_rd_o));

    assert_stall_bubble_R5: assert property (@(posedge clk) disable iff (rst)
        stall_i && !flush_i |=> !ex_valid_o && $stable(id_valid_o));

    assert_idle_mem_R6: assert property (@(posedge clk) disable iff (rst)
        !mem_valid_o |-> !mem_wr_o && !mem_branch_o);

    assert_idle_wb_R6: assert property (@(posedge clk) disable iff (rst)
        !wb_valid_o |-> !wb_reg_wr_o);

    assert_flush_clear_R7: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> !id_valid_o && !ex_valid_o && !mem_valid_o && !wb_valid_o);

    assert_flush_wins_R8: assert property (@(posedge clk) disable iff (rst)
        flush_i |-> !hold_o);
endmodule

bind ds_ctl_chain dsc_chain_chk u_chk (.*);

// File: tb/ds_ctl_chain_bench.sv
`timescale 1ns/1ps
module ds_ctl_chain_bench;
    import dsc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fetch_valid_i = 1'b0, stall_i = 1'b0, flush_i = 1'b0;
    idex_t dec = '0;
    logic hold_o, id_valid_o, ex_valid_o, mem_valid_o, wb_valid_o;
    logic [OP_W-1:0] ex_opcode_o, mem_opcode_o, wb_opcode_o;
    logic [REG_W-1:0] ex_rd_o, mem_rd_o, wb_rd_o;
    logic ex_ext_op_o, ex_alu_src_o, ex_dst_sel_o;
    logic [ALU_W-1:0] ex_alu_op_o;
    logic mem_wr_o, mem_branch_o, wb_reg_wr_o, wb_mem_to_reg_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ds_ctl_chain u_ds_ctl_chain (
        .clk(clk), .rst(rst), .fetch_valid_i(fetch_valid_i),
        .stall_i(stall_i), .flush_i(flush_i),
        .dec_opcode_i(dec.tag.opcode), .dec_rd_i(dec.tag.rd),
        .dec_reg_wr_i(dec.tag.reg_wr), .dec_ext_op_i(dec.ex.ext_op),
        .dec_alu_src_i(dec.ex.alu_src), .dec_alu_op_i(dec.ex.alu_op),
        .dec_dst_sel_i(dec.ex.dst_sel), .dec_mem_wr_i(dec.mem.mem_wr),
        .dec_branch_i(dec.mem.branch), .dec_mem_to_reg_i(dec.wb.mem_to_reg),
        .hold_o(hold_o), .id_valid_o(id_valid_o),
        .ex_valid_o(ex_valid_o), .ex_opcode_o(ex_opcode_o), .ex_rd_o(ex_rd_o),
        .ex_ext_op_o(ex_ext_op_o), .ex_alu_src_o(ex_alu_src_o),
        .ex_alu_op_o(ex_alu_op_o), .ex_dst_sel_o(ex_dst_sel_o),
        .mem_valid_o(mem_valid_o), .mem_opcode_o(mem_opcode_o), .mem_rd_o(mem_rd_o),
        .mem_wr_o(mem_wr_o), .mem_branch_o(mem_branch_o),
        .wb_valid_o(wb_valid_o), .wb_opcode_o(wb_opcode_o), .wb_rd_o(wb_rd_o),
        .wb_reg_wr_o(wb_reg_wr_o), .wb_mem_to_reg_o(wb_mem_to_reg_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic idex_t mk(input int op, input int rd, input bit rw,
                                 input int aop, input bit mw, input bit br, input bit m2r);
        idex_t s;
        s.tag.opcode = OP_W'(op);
        s.tag.rd = REG_W'(rd);
        s.tag.reg_wr = rw;
        s.ex.ext_op = 1'b1;
        s.ex.alu_src = rw;
        s.ex.alu_op = ALU_W'(aop);
        s.ex.dst_sel = ~rw;
        s.mem.mem_wr = mw;
        s.mem.branch = br;
        s.wb.mem_to_reg = m2r;
        return s;
    endfunction

    task automatic chk_ex(input string req, input idex_t s);
        chk(req, "ex_valid", int'(ex_valid_o), 1);
        chk(req, "ex_opcode", int'(ex_opcode_o), int'(s.tag.opcode));
        chk(req, "ex_rd", int'(ex_rd_o), int'(s.tag.rd));
        chk(req, "ex_alu_op", int'(ex_alu_op_o), int'(s.ex.alu_op));
        chk(req, "ex_alu_src", int'(ex_alu_src_o), int'(s.ex.alu_src));
        chk(req, "ex_ext_op", int'(ex_ext_op_o), int'(s.ex.ext_op));
        chk(req, "ex_dst_sel", int'(ex_dst_sel_o), int'(s.ex.dst_sel));
    endtask

    task automatic chk_mem(input string req, input idex_t s);
        chk(req, "mem_valid", int'(mem_valid_o), 1);
        chk(req, "mem_opcode", int'(mem_opcode_o), int'(s.tag.opcode));
        chk(req, "mem_rd", int'(mem_rd_o), int'(s.tag.rd));
        chk(req, "mem_wr", int'(mem_wr_o), int'(s.mem.mem_wr));
        chk(req, "mem_branch", int'(mem_branch_o), int'(s.mem.branch));
    endtask

    task automatic chk_wb(input string req, input idex_t s);
        chk(req, "wb_valid", int'(wb_valid_o), 1);
        chk(req, "wb_opcode", int'(wb_opcode_o), int'(s.tag.opcode));
        chk(req, "wb_rd", int'(wb_rd_o), int'(s.tag.rd));
        chk(req, "wb_reg_wr", int'(wb_reg_wr_o), int'(s.tag.reg_wr));
        chk(req, "wb_mem_to_reg", int'(wb_mem_to_reg_o), int'(s.wb.mem_to_reg));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        fetch_valid_i = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        fetch_valid_i = 1'b0;
        #1;
        chk("R1", "id_valid", int'(id_valid_o), 0);
        chk("R1", "ex_valid", int'(ex_valid_o), 0);
        chk("R1", "mem_valid", int'(mem_valid_o), 0);
        chk("R1", "wb_valid", int'(wb_valid_o), 0);
        chk("R6", "wb_reg_wr idle", int'(wb_reg_wr_o), 0);
        chk("R6", "mem_wr idle", int'(mem_wr_o), 0);
    endtask

    // One instruction walks the whole chain, sampled in each stage.
    task automatic t_single();
        idex_t a = mk(6'h23, 1, 1'b1, 2, 1'b0, 1'b0, 1'b1);
        fetch_valid_i = 1'b1;
        tick();
        chk("R9", "id_valid after fetch", int'(id_valid_o), 1);
        fetch_valid_i = 1'b0;
        dec = a;
        tick();
        chk_ex("R2", a);
        chk("R9", "id_valid empty fetch", int'(id_valid_o), 0);
        chk("R3", "mem_valid early", int'(mem_valid_o), 0);
        dec = '1;
        tick();
        chk_mem("R3", a);
        chk("R2", "ex_valid after", int'(ex_valid_o), 0);
        chk("R4", "wb_valid early", int'(wb_valid_o), 0);
        tick();
        chk_wb("R4", a);
        chk("R10", "wb_rd kept", int'(wb_rd_o), 1);
        tick();
        chk("R6", "wb drained reg_wr", int'(wb_reg_wr_o), 0);
    endtask

    // Back-to-back instructions stay separated stage by stage.
    task automatic t_stream();
        idex_t a = mk(6'h0a, 3, 1'b1, 5, 1'b0, 1'b0, 1'b0);
        idex_t b = mk(6'h2b, 9, 1'b0, 7, 1'b1, 1'b0, 1'b0);
        fetch_valid_i = 1'b1;
        tick();
        dec = a;
        tick();
        chk_ex("R2", a);
        fetch_valid_i = 1'b0;
        dec = b;
        tick();
        chk_ex("R10", b);
        chk_mem("R3", a);
        dec = '0;
        tick();
        chk_mem("R10", b);
        chk_wb("R4", a);
        tick();
        chk_wb("R4", b);
        tick();
    endtask

    // Stall with an older instruction in execute: it drains, a bubble follows.
    task automatic t_stall();
        idex_t a = mk(6'h08, 4, 1'b1, 1, 1'b0, 1'b0, 1'b0);
        idex_t b = mk(6'h04, 6, 1'b1, 9, 1'b1, 1'b1, 1'b1);
        fetch_valid_i = 1'b1;
        tick();
        dec = a;
        tick();
        dec = b;
        fetch_valid_i = 1'b0;
        stall_i = 1'b1;
        #1;
        chk("R5", "hold during stall", int'(hold_o), 1);
        tick();
        chk("R5", "id_valid held", int'(id_valid_o), 1);
        chk("R5", "bubble in ex", int'(ex_valid_o), 0);
        chk_mem("R5", a);
        stall_i = 1'b0;
        tick();
        chk_ex("R5", b);
        chk("R6", "bubble mem_valid", int'(mem_valid_o), 0);
        chk("R6", "bubble mem_wr", int'(mem_wr_o), 0);
        chk("R6", "bubble branch", int'(mem_branch_o), 0);
        chk_wb("R5", a);
        dec = '0;
        tick();
        chk("R6", "bubble wb reg_wr", int'(wb_reg_wr_o), 0);
        chk_mem("R3", b);
        repeat (2) tick();
    endtask

    task automatic t_flush();
        idex_t a = mk(6'h11, 2, 1'b1, 3, 1'b1, 1'b0, 1'b0);
        fetch_valid_i = 1'b1;
        dec = a;
        repeat (4) tick();
        chk("R7", "pre ex_valid", int'(ex_valid_o), 1);
        chk("R7", "pre wb_valid", int'(wb_valid_o), 1);
        flush_i = 1'b1;
        tick();
        flush_i = 1'b0;
        fetch_valid_i = 1'b0;
        chk("R7", "id_valid", int'(id_valid_o), 0);
        chk("R7", "ex_valid", int'(ex_valid_o), 0);
        chk("R7", "mem_valid", int'(mem_valid_o), 0);
        chk("R7", "wb_valid", int'(wb_valid_o), 0);
        chk("R6", "flushed wb reg_wr", int'(wb_reg_wr_o), 0);
        chk("R6", "flushed mem_wr", int'(mem_wr_o), 0);
        tick();
        chk("R7", "stays empty", int'(ex_valid_o), 0);
    endtask

    task automatic t_flush_stall();
        fetch_valid_i = 1'b1;
        dec = mk(6'h01, 5, 1'b1, 4, 1'b1, 1'b1, 1'b0);
        repeat (3) tick();
        stall_i = 1'b1;
        flush_i = 1'b1;
        #1;
        chk("R8", "hold low", int'(hold_o), 0);
        tick();
        stall_i = 1'b0;
        flush_i = 1'b0;
        fetch_valid_i = 1'b0;
        chk("R8", "id_valid", int'(id_valid_o), 0);
        chk("R8", "ex_valid", int'(ex_valid_o), 0);
        chk("R8", "mem_valid", int'(mem_valid_o), 0);
        chk("R8", "wb_valid", int'(wb_valid_o), 0);
        tick();
    endtask

    initial begin
        t_reset();
        t_single();
        t_stream();
        t_stall();
        t_flush();
        t_flush_stall();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog all-R actual=timeout expected=complete");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule